// File: doc/BRIEF.md
# Multi-threshold pulse amplitude classifier

This block sorts fast analog pulses into amplitude levels. It takes the outputs of a bank of comparators, and each comparator has a higher threshold than the one below it. A pulse that crosses a higher threshold always crosses every lower one too, so each narrower comparator pulse sits in time inside the wider pulses beneath it. The widest pulse lasts only a few nanoseconds and the pulses can repeat at 80 MHz, which is too fast to sample directly with a 200 MHz system clock. For this reason the rising edge of each input acts as the clock of its own toggle flop.

Each toggle output crosses into the system clock through a synchronizer chain whose length is a parameter, with a default of 2 stages. A change detector after the chain turns each flip of the toggle into an event that lasts one clock. Because of skew and metastability, the events from one analog pulse can land one clock apart. A grouping window therefore opens on the first event and collects events for that cycle and the next one. When the window closes, the block reports how many channels fired, together with a one-cycle valid strobe. If a higher channel fired while a lower one did not, the block raises an error flag alongside the result. A narrowest pulse that is too short to toggle its flop lowers the level by one but does not cause an error.

Top module: `pulse_level_classifier`

## Requirements
- R1: While `rst` is high, and on the first clock after `rst` falls, `levelValid` and `codeErr` are 0 and `levelOut` is 0. Input pulses that arrive while `rst` is high produce no result afterwards.
- R2: A rising edge on any bit of `pulseIn` that opens a window leads to `levelValid` being high in exactly the clock cycle that begins at the (SYNC_STAGES+2)-th rising `clk` edge after the input edge. With the default of 2 stages this is the 4th edge.
- R3: `levelOut` equals the number of distinct channels that produced an event in the two cycles of the window. The value lies between 1 and NUM_CH whenever `levelValid` is high.
- R4: A channel whose event arrives one cycle after the opening event is still counted in the same result.
- R5: `codeErr` is high together with `levelValid` exactly when the fired-channel set is not of the form {0..k-1}, meaning some channel i fired while channel i-1 did not (bit 0 is the lowest threshold). `codeErr` is never high without `levelValid`.
- R6: A window spans exactly two cycles. An event two cycles after the opening event starts a new window and produces a separate result.
- R7: `levelValid` is high for one cycle at a time. Each window produces exactly one result, and no result appears without an input edge.
- R8: Two rising edges on the same channel whose events fall in the same window count as one channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (200 MHz nominal) |
| rst | input | 1 | Asynchronous active-high reset |
| pulseIn | input | NUM_CH | Comparator pulses, bit 0 = lowest threshold |
| levelOut | output | $clog2(NUM_CH+1) | Number of channels fired in the window |
| levelValid | output | 1 | One-cycle strobe marking a result |
| codeErr | output | 1 | Fired set was not a contiguous run from bit 0 |

## Verification
The assertions check the following on every cycle: the window state always falls back to idle after one open cycle, the valid strobe never lasts two cycles, a reported level is never zero or above the channel count, and the error flag only appears together with a result. Only the bench scenarios can show that the right channels were counted and that the result arrives with the correct latency. These scenarios cover edges split across two cycles, missed narrow pulses, out-of-order threshold sets, repeated edges on one channel, windows placed back to back, and pulses applied during reset. A scoreboard matches each expected result against the cycle in which it appears.

// File: rtl/plc_pkg.sv
`timescale 1ns/1ps
package plc_pkg;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_OPEN = 1'b1} winState_t;

  typedef struct packed {
    logic capture;  // first cycle of a window: load the event set
    logic publish;  // second cycle: merge, count, emit
  } winStrobe_t;
endpackage

// File: rtl/plc_datapath.sv
`timescale 1ns/1ps
module plc_datapath
  import plc_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pulseIn,
  input  winStrobe_t        strobe,
  output logic              evAny,
  output logic [LVL_W-1:0]  levelOut,
  output logic              levelValid,
  output logic              codeErr
);
  logic [NUM_CH-1:0] chEvent;
  logic [NUM_CH-1:0] accMask;
  logic [NUM_CH-1:0] mergedMask;
  logic [LVL_W-1:0]  fireCount;
  logic              holeSeen;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic                   tog;
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   prevVal;

    // edge-clocked capture of a pulse too short for the system clock
    always_ff @(posedge pulseIn[g] or posedge rst) begin
      if (rst) tog <= 1'b0;
      else     tog <= ~tog;
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        syncChain <= '0;
        prevVal   <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], tog};
        prevVal   <= syncChain[SYNC_STAGES-1];
      end
    end

    assign chEvent[g] = syncChain[SYNC_STAGES-1] ^ prevVal;
  end

  assign evAny      = |chEvent;
  assign mergedMask = accMask | chEvent;

  always_comb begin
    fireCount = '0;
    for (int i = 0; i < NUM_CH; i++) fireCount = fireCount + LVL_W'(mergedMask[i]);
  end

  assign holeSeen = |(mergedMask[NUM_CH-1:1] & ~mergedMask[NUM_CH-2:0]);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      accMask    <= '0;
      levelOut   <= '0;
      levelValid <= 1'b0;
      codeErr    <= 1'b0;
    end else begin
      levelValid <= strobe.publish;
      codeErr    <= strobe.publish & holeSeen;
      if (strobe.publish) begin
        levelOut <= fireCount;
        accMask  <= '0;
      end else if (strobe.capture) begin
        accMask  <= chEvent;
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    levelValid |=> !levelValid);  // R7
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    codeErr |-> levelValid);  // R5
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    levelValid |-> (levelOut != '0 && levelOut <= LVL_W'(NUM_CH)));  // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!levelValid && !codeErr));  // R1
endmodule

// File: rtl/plc_control.sv
`timescale 1ns/1ps
module plc_control
  import plc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evAny,
  output winStrobe_t strobe
);
  winState_t state;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= WIN_IDLE;
    else if (state == WIN_OPEN) state <= WIN_IDLE;
    else if (evAny) state <= WIN_OPEN;
  end

  assign strobe.capture = (state == WIN_IDLE) && evAny;
  assign strobe.publish = (state == WIN_OPEN);

  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (rst)
    state == WIN_OPEN |=> state == WIN_IDLE);  // R6
  AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (rst)
    (state == WIN_IDLE && evAny) |=> state == WIN_OPEN);  // R2
endmodule

// File: rtl/pulse_level_classifier.sv
`timescale 1ns/1ps
module pulse_level_classifier
  import plc_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pulseIn,
  output logic [LVL_W-1:0]  levelOut,
  output logic              levelValid,
  output logic              codeErr
);
  winStrobe_t strobe;
  logic       evAny;

  plc_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .evAny  (evAny),
    .strobe (strobe)
  );

  plc_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .pulseIn    (pulseIn),
    .strobe     (strobe),
    .evAny      (evAny),
    .levelOut   (levelOut),
    .levelValid (levelValid),
    .codeErr    (codeErr)
  );
endmodule

// File: tb/pulse_level_classifier_tb_top.sv
`timescale 1ns/1ps
module pulse_level_classifier_tb_top;
  localparam real CLK_PERIOD  = 5.0;
  localparam int  NUM_CH      = 4;
  localparam int  SYNC_STAGES = 2;
  localparam int  LVL_W       = $clog2(NUM_CH + 1);

  typedef struct {
    int    lvl;
    bit    err;
    int    cyc;
    string tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] pulseIn = '0;
  logic [LVL_W-1:0]  levelOut;
  logic              levelValid;
  logic              codeErr;

  int       cycleCnt = 0;
  int       nChecks  = 0;
  int       nFails   = 0;
  bit       finished = 1'b0;
  expItem_t expQ[$];

  pulse_level_classifier #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk(clk), .rst(rst), .pulseIn(pulseIn),
    .levelOut(levelOut), .levelValid(levelValid), .codeErr(codeErr)
  );

  always #(CLK_PERIOD / 2.0) clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: raise early channels mid-cycle, late ones just after the next edge
  task automatic fire(input logic [NUM_CH-1:0] mask, input logic [NUM_CH-1:0] late,
                      input bit doPush, input string tag);
    expItem_t it;
    int       riseCyc;
    @(negedge clk);
    riseCyc = cycleCnt;
    #0.5 pulseIn = mask & ~late;
    if (late != '0) begin
      @(posedge clk);
      #0.5 pulseIn = mask;
    end
    #0.5 pulseIn = '0;
    if (doPush) begin
      it.lvl = $countones(mask);
      it.err = (mask & (mask + 1'b1)) != '0;
      it.cyc = riseCyc + SYNC_STAGES + 2;
      it.tag = tag;
      expQ.push_back(it);
    end
  endtask

  task automatic gap();
    repeat (8) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (!levelValid) begin
        check(codeErr == 1'b0, "R5 codeErr without valid", codeErr, 0);
      end else if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected result", levelOut, -1);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(int'(levelOut) == it.lvl, {it.tag, " level"}, levelOut, it.lvl);
        check(codeErr == it.err, {it.tag, " codeErr"}, codeErr, it.err);
        check(cycleCnt == it.cyc, {it.tag, " R2 latency"}, cycleCnt, it.cyc);
      end
    end
  end

  initial begin
    // pulses during reset must leave no trace (R1)
    repeat (2) @(negedge clk);
    pulseIn = 4'b0011; #0.5 pulseIn = '0;
    repeat (2) @(negedge clk);
    check(levelValid == 0 && codeErr == 0 && levelOut == 0, "R1 reset outputs",
          {levelValid, codeErr, levelOut}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(levelValid == 0 && levelOut == 0, "R1 first cycle after reset",
          {levelValid, levelOut}, 0);
    gap();

    fire(4'b1111, 4'b0000, 1, "R3 all four");
    gap();
    fire(4'b0001, 4'b0000, 1, "R3 lowest only");
    gap();
    fire(4'b0111, 4'b0000, 1, "R4 missed top");
    gap();
    fire(4'b1111, 4'b1100, 1, "R4 split across cycles");
    gap();
    fire(4'b0011, 4'b0010, 1, "R4 split pair");
    gap();
    fire(4'b1011, 4'b0000, 1, "R5 hole at bit2");
    gap();
    fire(4'b0100, 4'b0000, 1, "R5 lone upper");
    gap();
    fire(4'b1101, 4'b1000, 1, "R5 hole split");
    gap();
    // R8: second edge lands in the same window
    fire(4'b0001, 4'b0000, 1, "R8 repeat counted once");
    fire(4'b0001, 4'b0000, 0, "");
    gap();
    // R6: event two cycles after opening starts a new window
    fire(4'b0011, 4'b0000, 1, "R6 first window");
    @(negedge clk);
    fire(4'b0001, 4'b0000, 1, "R6 second window");
    gap();
    fire(4'b0111, 4'b0000, 1, "R3 three levels");
    gap();

    check(expQ.size() == 0, "R7 missing results", expQ.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycleCnt, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule